// File: doc/BRIEF.md
# Interrupt Error Status Register

This block gathers the error conditions found by a local interrupt controller into one 8-bit status register. Error strobes from the send path, the receive path and the register-access logic are ORed, cycle by cycle, into a hidden accumulator. Software cannot see the accumulator. A write of any value to the status address copies the accumulated errors into the readable register and empties the accumulator. Software therefore writes first and then reads, and a read returns only what was captured at the most recent write.

A vector entry sits next to the status register. It holds the interrupt vector for errors and a mask bit. When an accumulator bit goes from 0 to 1 and the entry is unmasked, the block raises a one-cycle interrupt request that carries the entry's vector. A bit that is already set raises no further request. The block checks its own register traffic as well. Programming the entry with a vector below 16 records an illegal-vector error. An access to an unused address records an illegal-register-address error.

Bit positions in the status register and in `err_i`: 0 send checksum, 1 receive checksum, 2 send accept, 3 receive accept, 4 reserved, 5 send illegal vector, 6 receive illegal vector, 7 illegal register address.

Top module: `err_status_ctrl`

## Requirements
- R1: The accumulator ORs `err_i` bits 0-3 and 5-7 on every cycle since the last status write. A strobe does not show in a status read until a status write follows it.
- R2: A write of any data to address 0 loads the status register with the accumulator ORed with that cycle's strobes, and clears the accumulator. Strobes that arrive in the write cycle are not kept for the next capture.
- R3: A read of address 0 returns the captured status, zero-extended. Bit 4 always reads 0, and `err_i[4]` has no effect.
- R4: Address 1 is the vector entry: the vector in bits 7:0 and the mask in bit 16. The entry resets to vector 0 with the mask set. A read returns exactly those fields, with every other bit 0.
- R5: When an accumulator bit goes 0 to 1 in a cycle where the entry's mask is clear, `irq_o` is high for the next cycle only, and `irq_vec_o` shows the entry's vector.
- R6: No request is raised while the mask is set. A strobe on a bit that is already set in the accumulator raises no request.
- R7: A write to address 1 whose data bits 7:0 are below 16 records bit 6 in the accumulator, even when the written mask bit is 1. Vector 16 records nothing.
- R8: A read or a write of address 2 or 3 records bit 7. Such a read returns 0, and such a write changes no register.
- R9: After reset the status register and the accumulator are 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_i | input | 8 | Error strobes, one per status bit |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid during a read request |
| irq_o | output | 1 | Error interrupt request pulse |
| irq_vec_o | output | 8 | Vector carried by the request |

## Verification
The hardest cases to reach from the ports are those where the hidden accumulator and the visible register disagree. One is a strobe that lands in the same cycle as the status write: it must be captured once and then dropped. The other is an illegal-vector write, which records an error through the register port itself rather than through `err_i`. The stimulus builds both cases directly. It pulses `err_i` in the write cycle, then performs two capture-and-read rounds. It also programs the entry with vectors 5, 7 and 16, while the mask is both set and clear. Repeated strobes on a bit that is already set, made with the entry unmasked, show whether a request is raised only on the 0-to-1 change.

// File: rtl/err_stat_pkg.sv
package err_stat_pkg;
  localparam int ERR_W       = 8;
  localparam int B_SND_CSUM  = 0;
  localparam int B_RCV_CSUM  = 1;
  localparam int B_SND_ACC   = 2;
  localparam int B_RCV_ACC   = 3;
  localparam int B_RSVD      = 4;
  localparam int B_SND_VEC   = 5;
  localparam int B_RCV_VEC   = 6;
  localparam int B_BAD_ADDR  = 7;

  typedef struct packed {
    logic stat_wr;
    logic stat_rd;
    logic entry_wr;
    logic entry_rd;
    logic bad_acc;
  } acc_dec_t;
endpackage

// File: rtl/err_addr_dec.sv
module err_addr_dec
  import err_stat_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int STAT_ADDR  = 0,
  parameter int ENTRY_ADDR = 1
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_dec_t          dec_o
);
  logic hit_stat, hit_entry;

  assign hit_stat  = (addr_i == ADDR_W'(STAT_ADDR));
  assign hit_entry = (addr_i == ADDR_W'(ENTRY_ADDR));

  always_comb begin
    dec_o          = '0;
    dec_o.stat_wr  = req_i &  we_i & hit_stat;
    dec_o.stat_rd  = req_i & ~we_i & hit_stat;
    dec_o.entry_wr = req_i &  we_i & hit_entry;
    dec_o.entry_rd = req_i & ~we_i & hit_entry;
    dec_o.bad_acc  = req_i & ~hit_stat & ~hit_entry;
  end
endmodule

// File: rtl/err_vec_entry.sv
module err_vec_entry #(
  parameter int DATA_W   = 32,
  parameter int VEC_W    = 8,
  parameter int MASK_POS = 16,
  parameter int MIN_VEC  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic              mask_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bad_vec_o
);
  logic [VEC_W-1:0] vec_q;
  logic             mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= '0;
      mask_q <= 1'b1;
    end else if (wr_i) begin
      vec_q  <= wdata_i[VEC_W-1:0];
      mask_q <= wdata_i[MASK_POS];
    end
  end

  // illegal-vector check ignores the mask being written
  assign bad_vec_o = wr_i & (wdata_i[VEC_W-1:0] < VEC_W'(MIN_VEC));

  always_comb begin
    rdata_o              = '0;
    rdata_o[VEC_W-1:0]   = vec_q;
    rdata_o[MASK_POS]    = mask_q;
  end

  assign vec_o  = vec_q;
  assign mask_o = mask_q;

  a_r4_entry_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i) |-> (vec_q == $past(wdata_i[VEC_W-1:0]) && mask_q == $past(wdata_i[MASK_POS])));
endmodule

// File: rtl/err_accum.sv
module err_accum #(
  parameter int              ERR_W     = 8,
  parameter logic [ERR_W-1:0] RSVD_MASK = 8'h10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ERR_W-1:0] strobe_i,
  input  logic             latch_i,
  input  logic             unmask_i,
  output logic [ERR_W-1:0] status_o,
  output logic [ERR_W-1:0] acc_o,
  output logic             irq_o
);
  logic [ERR_W-1:0] eff, acc_q, status_q, new_bits;
  logic             irq_q;

  assign eff      = strobe_i & ~RSVD_MASK;
  assign new_bits = eff & ~acc_q;

  for (genvar b = 0; b < ERR_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[b]    <= 1'b0;
        status_q[b] <= 1'b0;
      end else if (latch_i) begin
        acc_q[b]    <= 1'b0;
        status_q[b] <= acc_q[b] | eff[b];
      end else begin
        acc_q[b]    <= acc_q[b] | eff[b];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (|new_bits) & unmask_i;
  end

  assign status_o = status_q;
  assign acc_o    = acc_q;
  assign irq_o    = irq_q;

  a_r1_acc_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(latch_i) |-> ((acc_q & $past(acc_q)) == $past(acc_q)));
  a_r2_clear_on_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(latch_i) |-> (acc_q == '0));
  a_r3_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & RSVD_MASK) == '0 && (acc_q & RSVD_MASK) == '0);
  a_r6_irq_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(unmask_i));
endmodule

// File: rtl/err_status_ctrl.sv
module err_status_ctrl
  import err_stat_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 32,
  parameter int VEC_W    = 8,
  parameter int MASK_POS = 16,
  parameter int MIN_VEC  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ERR_W-1:0]  err_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  localparam logic [ERR_W-1:0] RSVD_MASK = ERR_W'(1) << B_RSVD;

  acc_dec_t          dec;
  logic [VEC_W-1:0]  vec;
  logic              mask, bad_vec;
  logic [DATA_W-1:0] entry_rdata;
  logic [ERR_W-1:0]  strobes, status, acc;

  err_addr_dec #(.ADDR_W(ADDR_W), .STAT_ADDR(0), .ENTRY_ADDR(1)) i_dec (
    .req_i (req_i),
    .we_i  (we_i),
    .addr_i(addr_i),
    .dec_o (dec)
  );

  err_vec_entry #(.DATA_W(DATA_W), .VEC_W(VEC_W), .MASK_POS(MASK_POS), .MIN_VEC(MIN_VEC)) i_entry (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (dec.entry_wr),
    .wdata_i  (wdata_i),
    .vec_o    (vec),
    .mask_o   (mask),
    .rdata_o  (entry_rdata),
    .bad_vec_o(bad_vec)
  );

  always_comb begin
    strobes             = err_i;
    strobes[B_RCV_VEC]  = err_i[B_RCV_VEC] | bad_vec;
    strobes[B_BAD_ADDR] = err_i[B_BAD_ADDR] | dec.bad_acc;
  end

  err_accum #(.ERR_W(ERR_W), .RSVD_MASK(RSVD_MASK)) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobes),
    .latch_i (dec.stat_wr),
    .unmask_i(~mask),
    .status_o(status),
    .acc_o   (acc),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (dec.stat_rd)       rdata_o = DATA_W'(status);
    else if (dec.entry_rd) rdata_o = entry_rdata;
  end

  assign irq_vec_o = vec;

  a_r7_bad_vec_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && we_i && addr_i == ADDR_W'(1) && wdata_i[VEC_W-1:0] < VEC_W'(MIN_VEC)
          && !(req_i && we_i && addr_i == ADDR_W'(0)))
    |-> acc[B_RCV_VEC]);
  a_r8_bad_addr_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && addr_i > ADDR_W'(1)) |-> acc[B_BAD_ADDR]);
  a_r3_rsvd_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(0)) |-> !rdata_o[B_RSVD]);
  a_r8_bad_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i > ADDR_W'(1)) |-> rdata_o == '0);
endmodule

// File: tb/test_err_status_ctrl.sv
module test_err_status_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  err_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  logic [7:0]  irq_vec_o;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  err_status_ctrl i_err_status_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_i(err_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .irq_vec_o(irq_vec_o)
  );

  // monitor: compares every read against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (req_i && !we_i) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (rdata_o !== e) begin
          bad++;
          $display("FAIL %s: rdata actual=%h expected=%h", t, rdata_o, e);
        end
      end
    end
  end

  task automatic idle();
    req_i = 0; we_i = 0; err_i = '0;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic strobe(input logic [7:0] e);
    err_i = e;
    @(negedge clk_i);
    err_i = '0;
  endtask

  task automatic chk_irq(input logic ex, input logic [7:0] ev, input string t);
    #1;
    total++;
    if (irq_o !== ex || (ex && irq_vec_o !== ev)) begin
      bad++;
      $display("FAIL %s: irq actual=%b/%h expected=%b/%h", t, irq_o, irq_vec_o, ex, ev);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    chk_irq(0, 0, "R9 irq after reset");
    rd(0, 32'h0, "R9 status after reset");
    rd(1, 32'h0001_0000, "R4 entry reset value");

    // R1: strobe is hidden until a capture write; masked so no request
    strobe(8'h01);
    chk_irq(0, 0, "R6 masked no irq");
    rd(0, 32'h0, "R1 not visible before write");
    wr(0, 32'h0);
    rd(0, 32'h01, "R2 captured bit0");
    rd(0, 32'h01, "R2 read repeatable");
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0, "R2 accumulator cleared");

    // R3: reserved bit ignored
    strobe(8'h10);
    wr(0, 32'h0);
    rd(0, 32'h0, "R3 reserved bit stays 0");

    // R4: entry fields
    wr(1, 32'hFFFE_FF41);
    rd(1, 32'h0000_0041, "R4 only vector and mask kept");
    wr(1, 32'h0000_0040);
    rd(1, 32'h0000_0040, "R4 entry readback");

    // R5/R6: unmasked requests only on 0->1
    strobe(8'h04);
    chk_irq(1, 8'h40, "R5 irq on new bit");
    idle();
    chk_irq(0, 0, "R5 single-cycle pulse");
    strobe(8'h04);
    chk_irq(0, 0, "R6 no repeat on set bit");
    strobe(8'h08);
    chk_irq(1, 8'h40, "R5 irq on second bit");
    wr(0, 0);
    rd(0, 32'h0C, "R1 OR of bits 2,3");

    // R6: masked
    wr(1, 32'h0001_0040);
    strobe(8'h02);
    chk_irq(0, 0, "R6 masked entry quiet");
    wr(0, 0);
    rd(0, 32'h02, "R6 error still recorded");

    // R7: illegal vector, written mask set
    wr(1, 32'h0001_0005);
    wr(0, 0);
    rd(0, 32'h40, "R7 low vector flags bit6 while masked");
    wr(1, 32'h0000_0040);
    wr(0, 0);
    wr(1, 32'h0000_0007);
    chk_irq(1, 8'h07, "R7 illegal vector raises irq when unmasked");
    wr(1, 32'h0001_0010);
    wr(0, 0);
    wr(0, 0);
    rd(0, 32'h0, "R7 vector 16 is legal");

    // R8: unused addresses
    rd(2, 32'h0, "R8 unused read returns 0");
    wr(0, 0);
    rd(0, 32'h80, "R8 read flags bit7");
    wr(3, 32'h0000_00FF);
    rd(1, 32'h0001_0010, "R8 unused write changes nothing");
    wr(0, 0);
    rd(0, 32'h80, "R8 write flags bit7");

    // R2: strobe in the capture cycle
    err_i = 8'h01;
    wr(0, 0);
    err_i = '0;
    rd(0, 32'h01, "R2 same-cycle strobe captured");
    wr(0, 0);
    rd(0, 32'h0, "R2 same-cycle strobe not kept");

    idle();
    idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule